// File: doc/BRIEF.md
# Multicast Group Hash Filter

This block decides whether a received frame addressed to a group (multicast) destination should be kept. The destination address arrives one byte per cycle, first byte first, qualified by a valid strobe. Every six valid bytes form one address. While the bytes stream in, the block accumulates an Ethernet CRC-32 over them. When the last byte arrives, it folds the CRC into an 8-bit index. That index selects one entry of a 256-entry bit table, and one cycle later the block raises a done pulse carrying an accept or reject decision.

The table is held as eight 32-bit words. Software changes one entry at a time with a set-or-clear write, and can read any whole word back. A promiscuous control forces every decision to accept. Addresses whose group bit is clear are left to a separate exact-match path, so this block reports them as no-match.

Top module: `mhf_filter`

## Requirements
- R1: After reset every table word reads as zero and `flt_done` is low.
- R2: The hash runs over the six address bytes in arrival order, each byte taken least-significant bit first. The shift register starts at all ones, shifts right with the reflected polynomial 0xEDB88320, and gets no final inversion. Index bit k equals register bit 7-k, which makes the index the top eight bits of the bit-reversed register.
- R3: For an address with its group bit set and promiscuous mode off, `flt_accept` is 1 exactly when the indexed table entry is 1.
- R4: Entry i lives in word i[7:5] at bit position 31 - i[4:0]. Entry 0 is bit 31 of word 0, and entry 255 is bit 0 of word 7.
- R5: A write with `tbl_wr` high changes only entry `tbl_wr_idx`, setting it when `tbl_wr_set` is 1 and clearing it otherwise. The new value is visible on `tbl_rd_data` in the next cycle.
- R6: `flt_done` is a one-cycle pulse that rises in the cycle after the sixth valid byte of an address. Cycles with `addr_valid` low do not advance the byte count.
- R7: When `promisc_en` is 1 in the cycle of the sixth byte, `flt_accept` is 1 whatever the address and the table hold.
- R8: An address whose group bit (bit 0 of the first byte) is 0 gets `flt_accept` = 0 unless promiscuous mode is on.
- R9: A table write in the same cycle as the sixth byte does not affect that address's decision; the lookup uses the table as it stood before the write.
- R10: `flt_accept` is never 1 while `flt_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_valid | input | 1 | Destination address byte valid |
| addr_byte | input | 8 | Destination address byte, first byte first |
| promisc_en | input | 1 | Accept every frame |
| tbl_wr | input | 1 | Write one table entry |
| tbl_wr_idx | input | 8 | Entry index for the write |
| tbl_wr_set | input | 1 | 1 sets the entry, 0 clears it |
| tbl_rd_sel | input | 3 | Table word to read |
| tbl_rd_data | output | 32 | Selected table word |
| flt_done | output | 1 | Decision strobe |
| flt_accept | output | 1 | Decision, valid with `flt_done` |

## Verification
Some properties are checked on every cycle. These are the pairing of accept with done, the single-cycle width of done and its link to a preceding valid byte, forced acceptance under promiscuous mode, the read-back of a freshly set or cleared entry, and the empty table after reset. Other behaviour can only be seen in the bench scenarios, where a behavioural model predicts every decision and every table word. That covers the correctness of the CRC-to-index fold, the word and bit placement of corner entries 0 and 255, the rejection of non-group addresses, byte counting across idle gaps, and the ordering of a write that lands in the same cycle as the final byte.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    parameter int unsigned MHF_WORDS      = 8;
    parameter int unsigned MHF_WORD_W     = 32;
    parameter int unsigned MHF_ADDR_BYTES = 6;

    localparam logic [31:0] MHF_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] MHF_CRC_SEED  = 32'hFFFF_FFFF;

    // Advance a right-shifting CRC register by one byte, LSB of the byte first.
    function automatic logic [31:0] mhf_crc_byte(input logic [31:0] crc_in,
                                                 input logic [7:0]  data);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            fb = c[0] ^ data[b];
            c  = c >> 1;
            if (fb) c = c ^ MHF_POLY_REFL;
        end
        return c;
    endfunction

endpackage

// File: rtl/mhf_addr_crc.sv
module mhf_addr_crc
    import mhf_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = MHF_ADDR_BYTES,
    localparam int unsigned CNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_vld,
    input  logic [7:0]  byte_in,
    output logic        last_o,
    output logic [31:0] crc_o,
    output logic        grp_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [31:0]      crc;
        logic             grp;
    } acc_t;

    acc_t acc_d, acc_q;

    logic        first_byte;
    logic [31:0] crc_upd;
    logic        grp_now;
    logic        last_now;

    always_comb begin
        first_byte = (acc_q.cnt == '0);
        crc_upd    = mhf_crc_byte(first_byte ? MHF_CRC_SEED : acc_q.crc, byte_in);
        grp_now    = first_byte ? byte_in[0] : acc_q.grp;
        last_now   = byte_vld && (acc_q.cnt == CNT_W'(ADDR_BYTES - 1));

        acc_d = acc_q;
        if (byte_vld) begin
            acc_d.cnt = last_now ? '0 : acc_q.cnt + 1'b1;
            acc_d.crc = crc_upd;
            acc_d.grp = grp_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '{cnt: '0, crc: MHF_CRC_SEED, grp: 1'b0};
        end else begin
            acc_q <= acc_d;
        end
    end

    assign last_o = last_now;
    assign crc_o  = crc_upd;
    assign grp_o  = grp_now;

endmodule

// File: rtl/mhf_group_table.sv
module mhf_group_table
    import mhf_pkg::*;
#(
    parameter int unsigned WORDS  = MHF_WORDS,
    parameter int unsigned WORD_W = MHF_WORD_W,
    localparam int unsigned IDX_W = $clog2(WORDS * WORD_W),
    localparam int unsigned BIT_W = $clog2(WORD_W),
    localparam int unsigned SEL_W = IDX_W - BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_set,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_hit,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WORD_W-1:0] rd_data
);

    typedef struct packed {
        logic [WORDS-1:0][WORD_W-1:0] w;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    // MSB-first numbering inside a word: position = WORD_W-1-offset,
    // which is the bitwise inverse of the offset for a power-of-two width.
    logic [SEL_W-1:0] wr_sel, lk_sel;
    logic [BIT_W-1:0] wr_pos, lk_pos;

    always_comb begin
        wr_sel = wr_idx[IDX_W-1:BIT_W];
        wr_pos = ~wr_idx[BIT_W-1:0];
        lk_sel = lk_idx[IDX_W-1:BIT_W];
        lk_pos = ~lk_idx[BIT_W-1:0];

        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.w[wr_sel][wr_pos] = wr_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign lk_hit  = tbl_q.w[lk_sel][lk_pos];
    assign rd_data = tbl_q.w[rd_sel];

endmodule

// File: rtl/mhf_decide.sv
module mhf_decide (
    input  logic clk,
    input  logic rst_n,
    input  logic last_i,
    input  logic grp_i,
    input  logic hit_i,
    input  logic promisc_i,
    output logic done_o,
    output logic accept_o
);

    typedef struct packed {
        logic done;
        logic accept;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d.done   = last_i;
        dec_d.accept = last_i && (promisc_i || (grp_i && hit_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign done_o   = dec_q.done;
    assign accept_o = dec_q.accept;

endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
    import mhf_pkg::*;
#(
    parameter int unsigned WORDS      = MHF_WORDS,
    parameter int unsigned WORD_W     = MHF_WORD_W,
    parameter int unsigned ADDR_BYTES = MHF_ADDR_BYTES,
    localparam int unsigned IDX_W = $clog2(WORDS * WORD_W),
    localparam int unsigned BIT_W = $clog2(WORD_W),
    localparam int unsigned SEL_W = IDX_W - BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_valid,
    input  logic [7:0]        addr_byte,
    input  logic              promisc_en,
    input  logic              tbl_wr,
    input  logic [IDX_W-1:0]  tbl_wr_idx,
    input  logic              tbl_wr_set,
    input  logic [SEL_W-1:0]  tbl_rd_sel,
    output logic [WORD_W-1:0] tbl_rd_data,
    output logic              flt_done,
    output logic              flt_accept
);

    logic             last_w;
    logic [31:0]      crc_w;
    logic             grp_w;
    logic [IDX_W-1:0] hash_idx;
    logic             hit_w;

    mhf_addr_crc #(.ADDR_BYTES(ADDR_BYTES)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (addr_valid),
        .byte_in  (addr_byte),
        .last_o   (last_w),
        .crc_o    (crc_w),
        .grp_o    (grp_w)
    );

    // Index = top IDX_W bits of the bit-reversed CRC register.
    for (genvar k = 0; k < IDX_W; k++) begin : g_fold
        assign hash_idx[k] = crc_w[IDX_W-1-k];
    end

    mhf_group_table #(.WORDS(WORDS), .WORD_W(WORD_W)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr),
        .wr_idx  (tbl_wr_idx),
        .wr_set  (tbl_wr_set),
        .lk_idx  (hash_idx),
        .lk_hit  (hit_w),
        .rd_sel  (tbl_rd_sel),
        .rd_data (tbl_rd_data)
    );

    mhf_decide u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_i    (last_w),
        .grp_i     (grp_w),
        .hit_i     (hit_w),
        .promisc_i (promisc_en),
        .done_o    (flt_done),
        .accept_o  (flt_accept)
    );

endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned BIT_W  = 5,
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_valid,
    input logic              promisc_en,
    input logic              tbl_wr,
    input logic [IDX_W-1:0]  tbl_wr_idx,
    input logic              tbl_wr_set,
    input logic [SEL_W-1:0]  tbl_rd_sel,
    input logic [WORD_W-1:0] tbl_rd_data,
    input logic              flt_done,
    input logic              flt_accept
);

    logic [SEL_W-1:0] wr_word;
    logic [BIT_W-1:0] wr_bit;
    assign wr_word = tbl_wr_idx[IDX_W-1:BIT_W];
    assign wr_bit  = ~tbl_wr_idx[BIT_W-1:0];

    // R10
    accept_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_accept |-> flt_done);

    // R6
    done_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_done |-> $past(addr_valid));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_done |=> !flt_done);

    // R7
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_done && $past(promisc_en)) |-> flt_accept);

    // R5
    entry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr && tbl_wr_set) |=>
            (tbl_rd_sel != $past(wr_word)) || tbl_rd_data[$past(wr_bit)]);

    // R5
    entry_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr && !tbl_wr_set) |=>
            (tbl_rd_sel != $past(wr_word)) || !tbl_rd_data[$past(wr_bit)]);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tbl_rd_data == '0) && !flt_done);

endmodule

bind mhf_filter mhf_filter_chk #(
    .IDX_W(IDX_W), .BIT_W(BIT_W), .SEL_W(SEL_W), .WORD_W(WORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_valid  (addr_valid),
    .promisc_en  (promisc_en),
    .tbl_wr      (tbl_wr),
    .tbl_wr_idx  (tbl_wr_idx),
    .tbl_wr_set  (tbl_wr_set),
    .tbl_rd_sel  (tbl_rd_sel),
    .tbl_rd_data (tbl_rd_data),
    .flt_done    (flt_done),
    .flt_accept  (flt_accept)
);

// File: tb/mhf_filter_tb.sv
`timescale 1ns/1ps
module mhf_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_valid = 1'b0;
    logic [7:0]  addr_byte = '0;
    logic        promisc_en = 1'b0;
    logic        tbl_wr = 1'b0;
    logic [7:0]  tbl_wr_idx = '0;
    logic        tbl_wr_set = 1'b0;
    logic [2:0]  tbl_rd_sel = '0;
    logic [31:0] tbl_rd_data;
    logic        flt_done, flt_accept;

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    bit cmp_on = 0;

    always #2 clk = ~clk;   // 250 MHz

    mhf_filter u_dut (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_byte(addr_byte),
        .promisc_en(promisc_en), .tbl_wr(tbl_wr), .tbl_wr_idx(tbl_wr_idx),
        .tbl_wr_set(tbl_wr_set), .tbl_rd_sel(tbl_rd_sel), .tbl_rd_data(tbl_rd_data),
        .flt_done(flt_done), .flt_accept(flt_accept)
    );

    // ---------------- behavioural reference ----------------
    bit [255:0] m_tbl;
    logic [7:0] m_buf [6];
    int         m_cnt;
    bit         e_done, e_acc, e_grp, e_prom;

    function automatic logic [7:0] ref_index(input logic [7:0] b0, b1, b2, b3, b4, b5);
        logic [7:0]  bytes [6];
        logic [31:0] r;
        logic [7:0]  ix;
        bytes = '{b0, b1, b2, b3, b4, b5};
        r = 32'hFFFF_FFFF;
        for (int n = 0; n < 6; n++)
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = r[0] ^ bytes[n][b];
                r  = {1'b0, r[31:1]} ^ (fb ? 32'hEDB8_8320 : 32'h0);
            end
        for (int k = 0; k < 8; k++) ix[k] = r[7-k];
        return ix;
    endfunction

    function automatic logic [7:0] idx_of(input logic [47:0] a);
        return ref_index(a[47:40], a[39:32], a[31:24], a[23:16], a[15:8], a[7:0]);
    endfunction

    function automatic logic [31:0] model_word(input int sel);
        logic [31:0] w;
        for (int b = 0; b < 32; b++) w[31-b] = m_tbl[sel*32 + b];
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tbl = '0; m_cnt = 0; e_done = 0; e_acc = 0;
        end else begin
            e_done = 0; e_acc = 0;
            if (addr_valid) begin
                m_buf[m_cnt] = addr_byte;
                if (m_cnt == 5) begin
                    e_done = 1;
                    e_grp  = m_buf[0][0];
                    e_prom = promisc_en;
                    e_acc  = promisc_en || (m_buf[0][0] &&
                             m_tbl[ref_index(m_buf[0], m_buf[1], m_buf[2],
                                             m_buf[3], m_buf[4], m_buf[5])]);
                    m_cnt = 0;
                end else begin
                    m_cnt++;
                end
            end
            if (tbl_wr) m_tbl[tbl_wr_idx] = tbl_wr_set;   // after lookup (R9)
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on && !finished) begin
            check(flt_done == e_done, "R6 done", 32'(flt_done), 32'(e_done));
            if (e_prom && e_done)
                check(flt_accept == e_acc, "R7 accept", 32'(flt_accept), 32'(e_acc));
            else if (e_done && !e_grp)
                check(flt_accept == e_acc, "R8 accept", 32'(flt_accept), 32'(e_acc));
            else
                check(flt_accept == e_acc, "R3 accept (R2 index)", 32'(flt_accept), 32'(e_acc));
            check(tbl_rd_data == model_word(int'(tbl_rd_sel)), "R5 word",
                  tbl_rd_data, model_word(int'(tbl_rd_sel)));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic write_entry(input logic [7:0] ix, input bit set);
        @(posedge clk); #1;
        tbl_wr = 1; tbl_wr_idx = ix; tbl_wr_set = set;
        @(posedge clk); #1;
        tbl_wr = 0;
    endtask

    task automatic send(input logic [47:0] a, input bit gaps, input bit wr_last,
                        input logic [7:0] wix, input bit wset);
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            addr_valid = 1; addr_byte = a[47-8*i -: 8];
            tbl_wr = wr_last && (i == 5); tbl_wr_idx = wix; tbl_wr_set = wset;
            if (gaps && i < 5) begin
                @(posedge clk); #1;
                addr_valid = 0; tbl_wr = 0;
            end
        end
        @(posedge clk); #1;
        addr_valid = 0; tbl_wr = 0;
        @(negedge clk);
    endtask

    task automatic expect_dec(input bit exp, input string req);
        check(flt_done == 1'b1, req, 32'(flt_done), 32'd1);
        check(flt_accept == exp, req, 32'(flt_accept), 32'(exp));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [47:0] a;
        logic [7:0]  ix;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: empty table, no decision after reset
        for (int s = 0; s < 8; s++) begin
            tbl_rd_sel = 3'(s);
            @(negedge clk);
            check(tbl_rd_data == 32'h0, "R1 reset word", tbl_rd_data, 32'h0);
            check(flt_done == 1'b0, "R1 reset done", 32'(flt_done), 32'h0);
            @(posedge clk); #1;
        end
        cmp_on = 1;

        // R3: group address with empty table is rejected
        a = 48'h01005E_00_00_FB;
        send(a, 0, 0, 0, 0);
        expect_dec(0, "R3 empty reject");

        // R4/R3: set its entry, word placement, then accept
        ix = idx_of(a);
        write_entry(ix, 1);
        tbl_rd_sel = ix[7:5];
        @(negedge clk);
        check(tbl_rd_data == (32'h1 << (31 - ix[4:0])), "R4 placement",
              tbl_rd_data, 32'h1 << (31 - ix[4:0]));
        send(a, 0, 0, 0, 0);
        expect_dec(1, "R3 hit accept");

        // R5: clear entry, rejected again
        write_entry(ix, 0);
        send(a, 0, 0, 0, 0);
        expect_dec(0, "R5 clear reject");

        // R4 corner entries
        write_entry(8'd0, 1);
        tbl_rd_sel = 3'd0;
        @(negedge clk);
        check(tbl_rd_data == 32'h8000_0000, "R4 entry0", tbl_rd_data, 32'h8000_0000);
        write_entry(8'd255, 1);
        tbl_rd_sel = 3'd7;
        @(negedge clk);
        check(tbl_rd_data == 32'h0000_0001, "R4 entry255", tbl_rd_data, 32'h1);

        // R8: non-group address whose entry is set is still rejected
        a = 48'h02_11_22_33_44_55;
        write_entry(idx_of(a), 1);
        send(a, 0, 0, 0, 0);
        expect_dec(0, "R8 unicast reject");

        // R7: promiscuous accepts unicast and unlisted group
        promisc_en = 1;
        send(48'h00_AA_BB_CC_DD_EE, 0, 0, 0, 0);
        expect_dec(1, "R7 promisc unicast");
        send(48'h03_00_00_00_00_07, 0, 0, 0, 0);
        expect_dec(1, "R7 promisc group");
        promisc_en = 0;

        // R6: idle gaps between bytes
        a = 48'h33_33_00_00_00_01;
        write_entry(idx_of(a), 1);
        send(a, 1, 0, 0, 0);
        expect_dec(1, "R6 gapped accept");
        @(posedge clk); #1;
        @(negedge clk);
        check(flt_done == 1'b0, "R6 single pulse", 32'(flt_done), 32'h0);

        // R9: write on the last byte does not affect this decision
        a = 48'h01_80_C2_00_00_0E;
        ix = idx_of(a);
        write_entry(ix, 0);
        send(a, 0, 1, ix, 1);
        expect_dec(0, "R9 same-cycle set");
        send(a, 0, 1, ix, 0);
        expect_dec(1, "R9 same-cycle clear");

        // mixed traffic, model compared every cycle
        for (int n = 0; n < 300; n++) begin
            a = {$urandom, $urandom};
            tbl_rd_sel = 3'($urandom);
            if ($urandom_range(0, 2) == 0) write_entry(idx_of(a), 1);
            promisc_en = ($urandom_range(0, 9) == 0);
            send(a, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
                 8'($urandom), $urandom_range(0, 1) == 1);
        end
        promisc_en = 0;
        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule